// File: doc/BRIEF.md
# Two-Port Banked Data-Cache Request Arbiter

This block stands between the execute stage and a data cache whose storage is split into a power-of-two number of address-interleaved banks. Each cycle it takes up to two memory requests. Each request carries a valid bit, a store flag and an address. The arbiter works out which bank each address falls in. In the same cycle it tells the execute stage which requests are accepted and which must wait. Bank-conflict stalls can only be decided once addresses are known, so the decision is combinational in the execute stage.

A bank accepts at most one access per cycle. Port 0 holds the older request and always wins. Port 1 is stalled when it targets the same bank as port 0, and also when either request is a store: two loads may go together, but a store must travel alone. A stalled request is held by the execute stage and presented again unchanged on the next cycle. The per-bank launch signals (request, write, source port) are registered and drive the bank arrays one cycle after the grant.

A parameter chooses how the bank number is taken from the address. In word-interleaved mode it comes from the bits just above the byte-in-word field, so one line is spread across all banks. In line-interleaved mode it comes from the lowest set-index bits, so each line stays within one bank.

Top module: `dcb_bank_arbiter`

## Requirements
- R1: After reset, and until the first granted access has been registered, `bankReq`, `bankWrite` and `bankSrc` are all zero.
- R2: A valid request on port 0 is always granted in the same cycle, and `p0Grant` is low whenever `p0Valid` is low.
- R3: With `BANK_FROM_INDEX`=0 the bank is address bits [3:2] (4-byte words, 4 banks). With `BANK_FROM_INDEX`=1 it is address bits [6:5] (32-byte lines, 4 banks).
- R4: Two valid loads that target different banks are both granted in the same cycle.
- R5: When both ports are valid and target the same bank, port 0 is granted and port 1 is stalled (`p1Stall`=1, `p1Grant`=0).
- R6: When both ports are valid and either of them is a store, port 1 is stalled whatever the banks are.
- R7: A store on one port with the other port idle is granted, on either port.
- R8: One cycle after an access to bank b is granted, `bankReq[b]`=1, `bankWrite[b]` equals its store flag, and `bankSrc[b]` is 0 for port 0 and 1 for port 1. Banks with no granted access show 0 in all three vectors.
- R9: No bank ever receives more than one granted access in a cycle, so the number of bits set in `bankReq` equals the number of grants of the previous cycle.
- R10: An invalid port 1 is neither granted nor stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| p0Valid | input | 1 | Port 0 (older) request present |
| p0Store | input | 1 | Port 0 request is a store |
| p0Addr | input | ADDR_W | Port 0 byte address |
| p1Valid | input | 1 | Port 1 (younger) request present |
| p1Store | input | 1 | Port 1 request is a store |
| p1Addr | input | ADDR_W | Port 1 byte address |
| p0Grant | output | 1 | Port 0 request accepted this cycle |
| p1Grant | output | 1 | Port 1 request accepted this cycle |
| p1Stall | output | 1 | Port 1 request must be presented again next cycle |
| bankReq | output | BANKS | Registered per-bank access strobe |
| bankWrite | output | BANKS | Registered per-bank write flag |
| bankSrc | output | BANKS | Registered per-bank source port (0 or 1) |

## Verification
On every cycle the assertions check that port 0 is never refused, that an idle port 1 is neither granted nor stalled, and that a same-bank or store-bearing pair stalls port 1. They also check that each grant reaches its bank's registered strobe and that the number of set strobes matches the grants one cycle earlier. The scenarios show what a property cannot pin down on its own: the exact address bits that select the bank in each interleave mode, which is checked by running identical traffic into one instance of each mode. They also show that a stalled request, presented again unchanged, eventually goes through, and that write and source flags reach the correct bank.

// File: rtl/dcb_arb_pkg.sv
`timescale 1ns/1ps
package dcb_arb_pkg;
  // strobes from the control to the datapath: which ports launch this cycle
  typedef struct packed {
    logic take0;
    logic take1;
  } arbStrobe_t;
endpackage

// File: rtl/dcb_arb_dpath.sv
`timescale 1ns/1ps
module dcb_arb_dpath
  import dcb_arb_pkg::*;
#(
  parameter int ADDR_W          = 32,
  parameter int BANKS           = 4,
  parameter int WORD_BYTES      = 4,
  parameter int LINE_BYTES      = 32,
  parameter bit BANK_FROM_INDEX = 1'b0
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          p0Addr,
  input  logic [ADDR_W-1:0]          p1Addr,
  input  logic                       p0Store,
  input  logic                       p1Store,
  input  arbStrobe_t                 strobe,
  output logic [$clog2(BANKS)-1:0]   bank0,
  output logic [$clog2(BANKS)-1:0]   bank1,
  output logic [BANKS-1:0]           bankReq,
  output logic [BANKS-1:0]           bankWrite,
  output logic [BANKS-1:0]           bankSrc
);
  localparam int BANK_W   = $clog2(BANKS);
  localparam int WORD_LSB = $clog2(WORD_BYTES);
  localparam int LINE_LSB = $clog2(LINE_BYTES);
  localparam logic [ADDR_W-1:0] BANK_MASK = ADDR_W'(BANKS - 1);

  // bank decode: the parameter picks which address field selects the bank
  generate
    if (BANK_FROM_INDEX) begin : g_lineInterleave
      assign bank0 = BANK_W'((p0Addr >> LINE_LSB) & BANK_MASK);
      assign bank1 = BANK_W'((p1Addr >> LINE_LSB) & BANK_MASK);
    end else begin : g_wordInterleave
      assign bank0 = BANK_W'((p0Addr >> WORD_LSB) & BANK_MASK);
      assign bank1 = BANK_W'((p1Addr >> WORD_LSB) & BANK_MASK);
    end
  endgenerate

  // one launch register set per bank
  generate
    for (genvar b = 0; b < BANKS; b++) begin : g_bank
      logic hit0, hit1;
      assign hit0 = strobe.take0 && (bank0 == BANK_W'(b));
      assign hit1 = strobe.take1 && (bank1 == BANK_W'(b));
      always_ff @(posedge clk) begin
        if (!rstN) begin
          bankReq[b]   <= 1'b0;
          bankWrite[b] <= 1'b0;
          bankSrc[b]   <= 1'b0;
        end else begin
          bankReq[b]   <= hit0 || hit1;
          bankWrite[b] <= hit0 ? p0Store : (hit1 && p1Store);
          bankSrc[b]   <= !hit0 && hit1;
        end
      end
    end
  endgenerate

  // R8
  port0_launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && strobe.take0) |=> (bankReq[$past(bank0)] && !bankSrc[$past(bank0)]
                                && bankWrite[$past(bank0)] == $past(p0Store)));
  // R8
  port1_launch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && strobe.take1) |=> (bankReq[$past(bank1)] && bankSrc[$past(bank1)]
                                && bankWrite[$past(bank1)] == $past(p1Store)));
  // R9
  bank_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> ($countones(bankReq) == $past(int'(strobe.take0) + int'(strobe.take1))));
endmodule

// File: rtl/dcb_arb_ctrl.sv
`timescale 1ns/1ps
module dcb_arb_ctrl
  import dcb_arb_pkg::*;
#(
  parameter int BANKS = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     p0Valid,
  input  logic                     p0Store,
  input  logic                     p1Valid,
  input  logic                     p1Store,
  input  logic [$clog2(BANKS)-1:0] bank0,
  input  logic [$clog2(BANKS)-1:0] bank1,
  output arbStrobe_t               strobe,
  output logic                     p0Grant,
  output logic                     p1Grant,
  output logic                     p1Stall
);
  logic bothValid, sameBank, storeInPair, refuse1;

  always_comb begin
    bothValid   = p0Valid && p1Valid;
    sameBank    = (bank0 == bank1);
    storeInPair = p0Store || p1Store;
    // older port wins; younger waits on bank clash or when a store is paired
    refuse1     = bothValid && (sameBank || storeInPair);
    strobe.take0 = p0Valid;
    strobe.take1 = p1Valid && !refuse1;
    p0Grant     = strobe.take0;
    p1Grant     = strobe.take1;
    p1Stall     = p1Valid && refuse1;
  end

  // R2
  older_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    p0Valid |-> p0Grant);
  // R10
  idle_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    !p1Valid |-> (!p1Grant && !p1Stall));
  // R5
  bank_clash_chk: assert property (@(posedge clk) disable iff (!rstN)
    (p0Valid && p1Valid && bank0 == bank1) |-> (p1Stall && !p1Grant));
  // R6
  store_alone_chk: assert property (@(posedge clk) disable iff (!rstN)
    (p0Valid && p1Valid && (p0Store || p1Store)) |-> (p1Stall && !p1Grant));
endmodule

// File: rtl/dcb_bank_arbiter.sv
`timescale 1ns/1ps
module dcb_bank_arbiter
  import dcb_arb_pkg::*;
#(
  parameter int ADDR_W          = 32,
  parameter int BANKS           = 4,
  parameter int WORD_BYTES      = 4,
  parameter int LINE_BYTES      = 32,
  parameter bit BANK_FROM_INDEX = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              p0Valid,
  input  logic              p0Store,
  input  logic [ADDR_W-1:0] p0Addr,
  input  logic              p1Valid,
  input  logic              p1Store,
  input  logic [ADDR_W-1:0] p1Addr,
  output logic              p0Grant,
  output logic              p1Grant,
  output logic              p1Stall,
  output logic [BANKS-1:0]  bankReq,
  output logic [BANKS-1:0]  bankWrite,
  output logic [BANKS-1:0]  bankSrc
);
  localparam int BANK_W = $clog2(BANKS);

  arbStrobe_t       strobe;
  logic [BANK_W-1:0] bank0, bank1;

  dcb_arb_dpath #(
    .ADDR_W(ADDR_W), .BANKS(BANKS), .WORD_BYTES(WORD_BYTES),
    .LINE_BYTES(LINE_BYTES), .BANK_FROM_INDEX(BANK_FROM_INDEX)
  ) uDpath (
    .clk(clk), .rstN(rstN), .p0Addr(p0Addr), .p1Addr(p1Addr),
    .p0Store(p0Store), .p1Store(p1Store), .strobe(strobe),
    .bank0(bank0), .bank1(bank1),
    .bankReq(bankReq), .bankWrite(bankWrite), .bankSrc(bankSrc)
  );

  dcb_arb_ctrl #(.BANKS(BANKS)) uCtrl (
    .clk(clk), .rstN(rstN),
    .p0Valid(p0Valid), .p0Store(p0Store),
    .p1Valid(p1Valid), .p1Store(p1Store),
    .bank0(bank0), .bank1(bank1), .strobe(strobe),
    .p0Grant(p0Grant), .p1Grant(p1Grant), .p1Stall(p1Stall)
  );
endmodule

// File: tb/sim_dcb_bank_arbiter.sv
`timescale 1ns/1ps
module sim_dcb_bank_arbiter;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic        v0 = 0, s0 = 0, v1 = 0, s1 = 0;
  logic [31:0] a0 = 0, a1 = 0;
  logic        g0A, g1A, stA, g0B, g1B, stB;
  logic [3:0]  reqA, wrA, srcA, reqB, wrB, srcB;

  int nChecks = 0;
  int nFail   = 0;

  // u0: word interleave, u1: line interleave, same traffic
  dcb_bank_arbiter #(.BANK_FROM_INDEX(1'b0)) u0 (
    .clk(clk), .rstN(rstN), .p0Valid(v0), .p0Store(s0), .p0Addr(a0),
    .p1Valid(v1), .p1Store(s1), .p1Addr(a1),
    .p0Grant(g0A), .p1Grant(g1A), .p1Stall(stA),
    .bankReq(reqA), .bankWrite(wrA), .bankSrc(srcA));
  dcb_bank_arbiter #(.BANK_FROM_INDEX(1'b1)) u1 (
    .clk(clk), .rstN(rstN), .p0Valid(v0), .p0Store(s0), .p0Addr(a0),
    .p1Valid(v1), .p1Store(s1), .p1Addr(a1),
    .p0Grant(g0B), .p1Grant(g1B), .p1Stall(stB),
    .bankReq(reqB), .bankWrite(wrB), .bankSrc(srcB));

  // R3: bank field per mode
  function automatic logic [1:0] bk(input logic [31:0] a, input bit m);
    return m ? a[6:5] : a[3:2];
  endfunction

  function automatic logic [2:0] expGrant(input logic iv0, is0, input logic [31:0] ia0,
                                          input logic iv1, is1, input logic [31:0] ia1,
                                          input bit m);
    logic clash, eg1;
    clash = iv0 && iv1 && (bk(ia0, m) == bk(ia1, m) || is0 || is1);
    eg1 = iv1 && !clash;
    return {iv0, eg1, iv1 && !eg1};
  endfunction

  function automatic logic [11:0] expBanks(input logic iv0, is0, input logic [31:0] ia0,
                                           input logic iv1, is1, input logic [31:0] ia1,
                                           input bit m);
    logic [2:0] g;
    logic [3:0] r, w, s;
    g = expGrant(iv0, is0, ia0, iv1, is1, ia1, m);
    r = 0; w = 0; s = 0;
    if (g[2]) begin r[bk(ia0, m)] = 1; w[bk(ia0, m)] = is0; end
    if (g[1]) begin r[bk(ia1, m)] = 1; w[bk(ia1, m)] = is1; s[bk(ia1, m)] = 1; end
    return {r, w, s};
  endfunction

  function automatic string classify(input logic iv0, is0, input logic [31:0] ia0,
                                     input logic iv1, is1, input logic [31:0] ia1,
                                     input bit m);
    if (!iv1) return iv0 ? (is0 ? "R7/R10" : "R2/R10") : "R10";
    if (!iv0) return is1 ? "R7" : "R2/R10";
    if (is0 || is1) return "R6";
    if (bk(ia0, m) == bk(ia1, m)) return "R5";
    return "R4";
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [11:0] prevA, prevB;
  bit          havePrev = 0;

  task automatic apply(input logic iv0, is0, input logic [31:0] ia0,
                       input logic iv1, is1, input logic [31:0] ia1);
    @(negedge clk);
    if (havePrev) begin
      chk("R8 word-mode bank launch", {20'd0, reqA, wrA, srcA}, {20'd0, prevA});
      chk("R8/R3 line-mode bank launch", {20'd0, reqB, wrB, srcB}, {20'd0, prevB});
    end
    v0 = iv0; s0 = is0; a0 = ia0; v1 = iv1; s1 = is1; a1 = ia1;
    #1;
    chk({classify(iv0, is0, ia0, iv1, is1, ia1, 0), " R3 word-mode grant"},
        {29'd0, g0A, g1A, stA}, {29'd0, expGrant(iv0, is0, ia0, iv1, is1, ia1, 0)});
    chk({classify(iv0, is0, ia0, iv1, is1, ia1, 1), " R3 line-mode grant"},
        {29'd0, g0B, g1B, stB}, {29'd0, expGrant(iv0, is0, ia0, iv1, is1, ia1, 1)});
    // R9: grants per bank in this cycle
    nChecks++;
    if ((g0A && g1A && bk(ia0, 0) == bk(ia1, 0)) || (g0B && g1B && bk(ia0, 1) == bk(ia1, 1))) begin
      nFail++;
      $display("FAIL R9 two grants to one bank actual=2 expected=1");
    end
    prevA = expBanks(iv0, is0, ia0, iv1, is1, ia1, 0);
    prevB = expBanks(iv0, is0, ia0, iv1, is1, ia1, 1);
    havePrev = 1;
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic pv1, ps1;
    logic [31:0] pa1;
    bit hold;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 word-mode reset outputs", {20'd0, reqA, wrA, srcA}, 32'd0);
    chk("R1 line-mode reset outputs", {20'd0, reqB, wrB, srcB}, 32'd0);

    apply(1, 0, 32'h100, 0, 0, 0);            // R2 lone load
    apply(1, 0, 32'h0,   1, 0, 32'h4);        // R4 word mode; R5 line mode
    apply(1, 0, 32'h0,   1, 0, 32'h10);       // R5 both modes
    apply(1, 0, 32'h0,   1, 0, 32'h20);       // R5 word mode; R4 line mode
    apply(1, 1, 32'h8,   1, 0, 32'h44);       // R6 store on port 0
    apply(1, 0, 32'h8,   1, 1, 32'h44);       // R6 store on port 1
    apply(0, 0, 32'h0,   1, 1, 32'h44);       // R7 lone store port 1
    apply(1, 1, 32'h6c,  0, 0, 32'h0);        // R7 lone store port 0
    apply(0, 0, 32'h0,   1, 0, 32'hc);        // R10 port 0 idle
    apply(0, 0, 32'h0,   0, 0, 32'h0);        // R10 all idle
    apply(0, 0, 32'h0,   0, 0, 32'h0);        // R8 outputs clear again

    hold = 0; pv1 = 0; ps1 = 0; pa1 = 0;
    for (int i = 0; i < 3000; i++) begin
      logic rv0, rs0, rv1, rs1;
      logic [31:0] ra0, ra1;
      rv0 = ($urandom % 4) != 0;
      rs0 = ($urandom % 4) == 0;
      ra0 = $urandom & 32'hff;
      if (hold) begin rv1 = pv1; rs1 = ps1; ra1 = pa1; end
      else begin
        rv1 = ($urandom % 4) != 0;
        rs1 = ($urandom % 5) == 0;
        ra1 = $urandom & 32'hff;
      end
      apply(rv0, rs0, ra0, rv1, rs1, ra1);
      // stalled request comes back unchanged (word-mode instance drives the hold)
      hold = stA; pv1 = rv1; ps1 = rs1; pa1 = ra1;
    end
    apply(0, 0, 0, 0, 0, 0);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule